// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits next to a small CPU core and takes care of entering exception handlers. It watches a hardware-reset request, one non-maskable interrupt (NMI) line and six maskable request lines. At each instruction boundary, signalled by a strobe from the core, it picks at most one request. A reset request always wins. An NMI wins over maskable sources unless NMI handling is already in progress. Maskable sources are gated by the interrupt-disable and NMI-busy flags of the status word.

When a request is accepted, the controller saves the core's current PC and status word into a backup pair. NMIs use one pair and maskable interrupts use another. It writes the cause code into one half of a 32-bit cause register, computes the status word the core must load, and pulses a redirect strobe with the handler address. An NMI that arrives while one is being handled is held in a single, non-counting latch. A clear-NP input from the core's return path releases that block.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While the asynchronous reset is asserted, and one cycle after a boundary that carries a reset request, the redirect PC is 0, the new status word is 0x20 and the cause register is 0. A reset request also drops any pending NMI, pending maskable requests and the NMI-busy state.
- R2: At one boundary at most one request is taken. The order is reset request, then NMI, then maskable source 0 (lowest vector) up to source 5.
- R3: On NMI entry, `fepc`/`fepsw` capture `pcIn`/`swIn`, and the redirect PC is 0x10. The new status word is `swIn` with bit 7 (NP) and bit 5 (ID) set and bit 6 (EP) cleared. The cause upper half (bits 31:16) becomes 0x0010, and the lower half keeps its value.
- R4: An NMI is not taken while status bit 7 of `swIn` is set or while an internally tracked NMI is still unreleased. Such an NMI stays latched, is retried at every later boundary, and any number of NMI pulses during the block yield one entry only.
- R5: When an NMI is taken from the latch and a new NMI pulse arrives in the same cycle, the latch stays set and gives one more NMI entry later.
- R6: On maskable entry, `eipc`/`eipsw` capture `pcIn`/`swIn`. The new status word is `swIn` with bit 5 (ID) set and bit 6 (EP) cleared.
- R7: On maskable entry from source k (0..5), the redirect PC and the cause lower half (bits 15:0) both become 0x80 + 0x10*k. The cause upper half keeps its value.
- R8: A maskable source is not taken while bit 5 or bit 7 of `swIn` is set or an NMI is unreleased. Request inputs are level-sensitive, and a seen request stays pending until that source is taken.
- R9: A one-cycle pulse on `clrNp` releases the internal NMI block, so a latched NMI is taken at the next boundary when `swIn` bit 7 is clear.
- R10: `redirect` is high for exactly the cycle after a boundary at which a request was taken, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| atBoundary | input | 1 | Instruction-boundary strobe from the core |
| resetReq | input | 1 | Hardware-reset request |
| nmiReq | input | 1 | Non-maskable interrupt pulse |
| irqReq | input | 6 | Maskable request levels, bit k is source k |
| clrNp | input | 1 | Release of NMI busy from the return path |
| pcIn | input | 32 | Core PC at the boundary |
| swIn | input | 32 | Core status word at the boundary |
| redirect | output | 1 | One-cycle redirect strobe |
| redirectPc | output | 32 | Handler address to load |
| newSw | output | 32 | Status word to load |
| cause | output | 32 | Cause register, NMI code in 31:16, maskable code in 15:0 |
| fepc | output | 32 | PC saved on NMI entry |
| fepsw | output | 32 | Status word saved on NMI entry |
| eipc | output | 32 | PC saved on maskable entry |
| eipsw | output | 32 | Status word saved on maskable entry |

## Verification
Every result of an acceptance appears one rising edge after the boundary that took it. This covers the redirect pulse, the handler PC, the new status word, the cause halves and the backup pairs. The pending latches update at that same edge and affect only the next boundary. Inputs are driven on the falling edge. A behavioural model advances on each rising edge, and all eight outputs are compared against it at the following falling edge. Directed checks sample in that same half-cycle window.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Status-word flag positions; the reset value 0x20 relies on ID at bit 5.
  localparam int unsigned SW_ID_BIT = 5;
  localparam int unsigned SW_EP_BIT = 6;
  localparam int unsigned SW_NP_BIT = 7;

  // Cause register is split into two independent halfword fields.
  localparam int unsigned CAUSE_HALF_W = 16;

  // Source index width carried in the strobe bundle (up to 16 sources).
  localparam int unsigned SRC_IDX_W = 4;

  typedef struct packed {
    logic                 takeReset;
    logic                 takeNmi;
    logic                 takeMask;
    logic [SRC_IDX_W-1:0] srcIdx;
  } entryStrobe_t;

endpackage

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned SW_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               atBoundary,
  input  logic               resetReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               clrNp,
  input  logic [SW_W-1:0]    swIn,
  output entryStrobe_t       strb
);

  logic               nmiPend;
  logic               npHeld;
  logic [NUM_SRC-1:0] srcPend;

  logic               nmiAvail;
  logic [NUM_SRC-1:0] srcAvail;
  logic               nmiBlocked;
  logic               maskBlocked;
  logic               anySrc;
  logic [SRC_IDX_W-1:0] pickIdx;
  logic [NUM_SRC-1:0] srcClr;
  logic               nmiGo;

  // A request seen in the boundary cycle itself counts as present.
  assign nmiAvail    = nmiPend | nmiReq;
  assign srcAvail    = srcPend | irqReq;
  assign nmiBlocked  = npHeld | swIn[SW_NP_BIT];
  assign maskBlocked = nmiBlocked | swIn[SW_ID_BIT];

  // Lowest-numbered pending source wins among maskables.
  always_comb begin
    anySrc  = 1'b0;
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcAvail[i]) begin
        anySrc  = 1'b1;
        pickIdx = SRC_IDX_W'(i);
      end
    end
  end

  assign nmiGo = nmiAvail & ~nmiBlocked;

  always_comb begin
    strb           = '0;
    strb.takeReset = atBoundary & resetReq;
    strb.takeNmi   = atBoundary & ~resetReq & nmiGo;
    strb.takeMask  = atBoundary & ~resetReq & ~nmiGo & anySrc & ~maskBlocked;
    strb.srcIdx    = pickIdx;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gClr
    assign srcClr[g] = strb.takeMask && (strb.srcIdx == SRC_IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPend <= 1'b0;
      npHeld  <= 1'b0;
      srcPend <= '0;
    end else if (strb.takeReset) begin
      nmiPend <= 1'b0;
      npHeld  <= 1'b0;
      srcPend <= '0;
    end else begin
      // Taking an NMI consumes one; a fresh pulse in the same cycle keeps it set.
      nmiPend <= strb.takeNmi ? (nmiPend & nmiReq) : nmiAvail;
      npHeld  <= strb.takeNmi | (npHeld & ~clrNp);
      srcPend <= srcAvail & ~srcClr;
    end
  end

  AST_NMI_UNBLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeNmi |-> !npHeld && !swIn[SW_NP_BIT]); // R4

  AST_NMI_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && !strb.takeNmi && !strb.takeReset |=> nmiPend); // R4

  AST_NMI_SECOND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeNmi && nmiPend && nmiReq |=> nmiPend); // R5

  AST_MASK_UNBLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeMask |-> !npHeld && !swIn[SW_NP_BIT] && !swIn[SW_ID_BIT]); // R8

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeReset || strb.takeNmi || strb.takeMask) |-> atBoundary); // R10

  AST_NP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    clrNp && !strb.takeNmi |=> !npHeld); // R9

  for (genvar g = 0; g < NUM_SRC; g++) begin : gPendChk
    AST_SRC_PEND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      srcPend[g] && !srcClr[g] && !strb.takeReset |=> srcPend[g]); // R8
  end

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned SW_W         = 32,
  parameter int unsigned NMI_VEC      = 'h10,
  parameter int unsigned SRC_VEC_BASE = 'h80,
  parameter int unsigned SRC_VEC_STEP = 'h10,
  parameter int unsigned RESET_SW     = 'h20
) (
  input  logic            clk,
  input  logic            rstN,
  input  entryStrobe_t    strb,
  input  logic [PC_W-1:0] pcIn,
  input  logic [SW_W-1:0] swIn,
  output logic            redirect,
  output logic [PC_W-1:0] redirectPc,
  output logic [SW_W-1:0] newSw,
  output logic [2*CAUSE_HALF_W-1:0] cause,
  output logic [PC_W-1:0] fepc,
  output logic [SW_W-1:0] fepsw,
  output logic [PC_W-1:0] eipc,
  output logic [SW_W-1:0] eipsw
);

  localparam logic [CAUSE_HALF_W-1:0] NMI_CODE = CAUSE_HALF_W'(NMI_VEC);
  localparam logic [SW_W-1:0]         SW_AT_RESET = SW_W'(RESET_SW);

  logic [CAUSE_HALF_W-1:0] causeHi;
  logic [CAUSE_HALF_W-1:0] causeLo;
  logic [CAUSE_HALF_W-1:0] srcVec;
  logic [SW_W-1:0]         nmiSw;
  logic [SW_W-1:0]         maskSw;
  logic                    anyTake;

  // Vector and cause code are one value: base plus a fixed stride per source.
  assign srcVec = CAUSE_HALF_W'(SRC_VEC_BASE)
                + CAUSE_HALF_W'(strb.srcIdx) * CAUSE_HALF_W'(SRC_VEC_STEP);

  always_comb begin
    nmiSw            = swIn;
    nmiSw[SW_NP_BIT] = 1'b1;
    nmiSw[SW_ID_BIT] = 1'b1;
    nmiSw[SW_EP_BIT] = 1'b0;
    maskSw            = swIn;
    maskSw[SW_ID_BIT] = 1'b1;
    maskSw[SW_EP_BIT] = 1'b0;
  end

  assign anyTake = strb.takeReset | strb.takeNmi | strb.takeMask;
  assign cause   = {causeHi, causeLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirect   <= 1'b0;
      redirectPc <= '0;
      newSw      <= SW_AT_RESET;
      causeHi    <= '0;
      causeLo    <= '0;
      fepc       <= '0;
      fepsw      <= '0;
      eipc       <= '0;
      eipsw      <= '0;
    end else begin
      redirect <= anyTake;
      if (strb.takeReset) begin
        redirectPc <= '0;
        newSw      <= SW_AT_RESET;
        causeHi    <= '0;
        causeLo    <= '0;
      end else if (strb.takeNmi) begin
        fepc       <= pcIn;
        fepsw      <= swIn;
        causeHi    <= NMI_CODE;
        redirectPc <= PC_W'(NMI_VEC);
        newSw      <= nmiSw;
      end else if (strb.takeMask) begin
        eipc       <= pcIn;
        eipsw      <= swIn;
        causeLo    <= srcVec;
        redirectPc <= PC_W'(srcVec);
        newSw      <= maskSw;
      end
    end
  end

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.takeReset) |-> redirectPc == '0 && newSw == SW_AT_RESET && cause == '0); // R1

  AST_NMI_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.takeNmi) |-> redirectPc == PC_W'(NMI_VEC) && newSw[SW_NP_BIT]
      && newSw[SW_ID_BIT] && !newSw[SW_EP_BIT] && fepc == $past(pcIn)
      && causeHi == NMI_CODE && causeLo == $past(causeLo)); // R3

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.takeMask) |-> newSw[SW_ID_BIT] && !newSw[SW_EP_BIT]
      && eipc == $past(pcIn) && eipsw == $past(swIn)); // R6

  AST_CAUSE_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.takeMask) |-> causeHi == $past(causeHi)
      && causeLo == redirectPc[CAUSE_HALF_W-1:0]); // R7

  AST_REDIRECT_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(anyTake)); // R10

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 6,
  parameter int unsigned PC_W         = 32,
  parameter int unsigned SW_W         = 32,
  parameter int unsigned NMI_VEC      = 'h10,
  parameter int unsigned SRC_VEC_BASE = 'h80,
  parameter int unsigned SRC_VEC_STEP = 'h10,
  parameter int unsigned RESET_SW     = 'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               atBoundary,
  input  logic               resetReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               clrNp,
  input  logic [PC_W-1:0]    pcIn,
  input  logic [SW_W-1:0]    swIn,
  output logic               redirect,
  output logic [PC_W-1:0]    redirectPc,
  output logic [SW_W-1:0]    newSw,
  output logic [31:0]        cause,
  output logic [PC_W-1:0]    fepc,
  output logic [SW_W-1:0]    fepsw,
  output logic [PC_W-1:0]    eipc,
  output logic [SW_W-1:0]    eipsw
);

  entryStrobe_t strb;

  irq_entry_ctl #(
    .NUM_SRC (NUM_SRC),
    .SW_W    (SW_W)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .atBoundary (atBoundary),
    .resetReq   (resetReq),
    .nmiReq     (nmiReq),
    .irqReq     (irqReq),
    .clrNp      (clrNp),
    .swIn       (swIn),
    .strb       (strb)
  );

  irq_entry_dp #(
    .PC_W         (PC_W),
    .SW_W         (SW_W),
    .NMI_VEC      (NMI_VEC),
    .SRC_VEC_BASE (SRC_VEC_BASE),
    .SRC_VEC_STEP (SRC_VEC_STEP),
    .RESET_SW     (RESET_SW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pcIn       (pcIn),
    .swIn       (swIn),
    .redirect   (redirect),
    .redirectPc (redirectPc),
    .newSw      (newSw),
    .cause      (cause),
    .fepc       (fepc),
    .fepsw      (fepsw),
    .eipc       (eipc),
    .eipsw      (eipsw)
  );

endmodule

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctrl_bench;

  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        atBoundary, resetReq, nmiReq, clrNp;
  logic [NS-1:0] irqReq;
  logic [31:0] pcIn, swIn;
  logic        redirect;
  logic [31:0] redirectPc, newSw, cause, fepc, fepsw, eipc, eipsw;

  always #10 clk = ~clk;

  irq_entry_ctrl u_irq_entry_ctrl (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .resetReq(resetReq),
    .nmiReq(nmiReq), .irqReq(irqReq), .clrNp(clrNp), .pcIn(pcIn), .swIn(swIn),
    .redirect(redirect), .redirectPc(redirectPc), .newSw(newSw), .cause(cause),
    .fepc(fepc), .fepsw(fepsw), .eipc(eipc), .eipsw(eipsw)
  );

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Behavioural reference state
  logic        eRedir;
  logic [31:0] ePc, eSw, eCause, eFepc, eFepsw, eEipc, eEipsw;
  logic        mN, mH;
  logic [NS-1:0] mP, mAvail;
  logic        mNAvail, mNBlk, mMBlk;
  int          pick;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eRedir = 0; ePc = 0; eSw = 32'h20; eCause = 0;
      eFepc = 0; eFepsw = 0; eEipc = 0; eEipsw = 0;
      mN = 0; mH = 0; mP = 0;
    end else begin
      eRedir  = 0;
      mAvail  = mP | irqReq;
      mNAvail = mN | nmiReq;
      mNBlk   = mH | swIn[7];
      mMBlk   = mNBlk | swIn[5];
      pick = -1;
      for (int i = NS - 1; i >= 0; i--) if (mAvail[i]) pick = i;
      if (atBoundary && resetReq) begin
        eRedir = 1; ePc = 0; eSw = 32'h20; eCause = 0;
        mN = 0; mP = 0; mH = 0;
      end else if (atBoundary && mNAvail && !mNBlk) begin
        eRedir = 1; eFepc = pcIn; eFepsw = swIn;
        eCause = {16'h0010, eCause[15:0]};
        eSw = (swIn | 32'hA0) & ~32'h40;
        ePc = 32'h10;
        mN = mN & nmiReq; mH = 1; mP = mAvail;
      end else if (atBoundary && pick >= 0 && !mMBlk) begin
        eRedir = 1; eEipc = pcIn; eEipsw = swIn;
        ePc = 32'h80 + 32'(pick) * 32'h10;
        eCause = {eCause[31:16], ePc[15:0]};
        eSw = (swIn | 32'h20) & ~32'h40;
        mAvail[pick] = 1'b0;
        mP = mAvail; mN = mNAvail; mH = mH & ~clrNp;
      end else begin
        mP = mAvail; mN = mNAvail; mH = mH & ~clrNp;
      end
    end
  end

  // Every-cycle comparison with the reference, away from the rising edge
  always @(negedge clk) begin
    chk(curReq, "redirect",   {31'b0, redirect}, {31'b0, eRedir});
    chk(curReq, "redirectPc", redirectPc, ePc);
    chk(curReq, "newSw",      newSw, eSw);
    chk(curReq, "cause",      cause, eCause);
    chk(curReq, "fepc",       fepc, eFepc);
    chk(curReq, "fepsw",      fepsw, eFepsw);
    chk(curReq, "eipc",       eipc, eEipc);
    chk(curReq, "eipsw",      eipsw, eEipsw);
  end

  task automatic idle();
    atBoundary = 0; resetReq = 0; nmiReq = 0; clrNp = 0; irqReq = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; idle(); pcIn = 32'h1000; swIn = 0;
    repeat (3) tick();
    chk("R1", "reset redirectPc", redirectPc, 32'h0);
    chk("R1", "reset newSw", newSw, 32'h20);
    chk("R1", "reset cause", cause, 32'h0);
    rstN = 1;
    tick();

    // Maskable entry from source 2
    curReq = "R7";
    swIn = 32'h0; pcIn = 32'h1234; irqReq = 6'b000100; atBoundary = 1;
    tick(); idle();
    chk("R7", "vector src2", redirectPc, 32'hA0);
    chk("R7", "cause src2", cause, 32'h0000_00A0);
    chk("R6", "eipc", eipc, 32'h1234);
    chk("R6", "newSw", newSw, 32'h20);
    chk("R10", "redirect pulse", {31'b0, redirect}, 32'h1);
    tick();
    chk("R10", "redirect low", {31'b0, redirect}, 32'h0);

    // NMI together with two maskables: NMI first
    curReq = "R2";
    pcIn = 32'h2000; irqReq = 6'b101000; nmiReq = 1; atBoundary = 1;
    tick(); idle();
    chk("R2", "nmi wins", redirectPc, 32'h10);
    chk("R3", "fepc", fepc, 32'h2000);
    chk("R3", "nmi newSw", newSw, 32'hA0);
    chk("R3", "cause halves", cause, 32'h0010_00A0);

    curReq = "R8";
    atBoundary = 1; tick(); idle();
    chk("R8", "blocked by held nmi", {31'b0, redirect}, 32'h0);
    clrNp = 1; swIn = 32'h20; tick(); idle();
    atBoundary = 1; tick(); idle();
    chk("R8", "blocked by ID", {31'b0, redirect}, 32'h0);
    swIn = 32'h0; atBoundary = 1; tick(); idle();
    chk("R8", "pending src3 taken", redirectPc, 32'hB0);
    chk("R7", "upper half kept", cause, 32'h0010_00B0);
    atBoundary = 1; tick(); idle();
    chk("R2", "src5 after src3", redirectPc, 32'hD0);
    chk("R7", "cause src5", cause, 32'h0010_00D0);

    // NMI hold and non-counting
    curReq = "R4";
    nmiReq = 1; atBoundary = 1; tick(); idle();
    chk("R4", "first nmi", redirectPc, 32'h10);
    nmiReq = 1; tick(); idle(); tick();
    nmiReq = 1; atBoundary = 1; tick(); idle();
    chk("R4", "held while busy", {31'b0, redirect}, 32'h0);
    atBoundary = 1; tick(); idle();
    chk("R4", "still held", {31'b0, redirect}, 32'h0);
    curReq = "R9";
    clrNp = 1; tick(); idle();
    atBoundary = 1; tick(); idle();
    chk("R9", "released nmi taken", {31'b0, redirect}, 32'h1);
    clrNp = 1; tick(); idle();
    atBoundary = 1; tick(); idle();
    chk("R4", "not counted", {31'b0, redirect}, 32'h0);

    // Second NMI kept when first is taken
    curReq = "R5";
    swIn = 32'h80; nmiReq = 1; atBoundary = 1; tick(); idle();
    chk("R4", "blocked by status NP", {31'b0, redirect}, 32'h0);
    swIn = 32'h0; nmiReq = 1; atBoundary = 1; tick(); idle();
    chk("R5", "latched nmi taken", redirectPc, 32'h10);
    clrNp = 1; tick(); idle();
    atBoundary = 1; tick(); idle();
    chk("R5", "second nmi taken", {31'b0, redirect}, 32'h1);
    clrNp = 1; tick(); idle();
    atBoundary = 1; tick(); idle();
    chk("R5", "no third nmi", {31'b0, redirect}, 32'h0);

    // Reset request beats everything and clears pending state
    curReq = "R1";
    resetReq = 1; nmiReq = 1; irqReq = 6'b000001; atBoundary = 1; tick(); idle();
    chk("R1", "reset pc", redirectPc, 32'h0);
    chk("R1", "reset sw", newSw, 32'h20);
    chk("R1", "reset cause", cause, 32'h0);
    atBoundary = 1; tick(); idle();
    chk("R1", "pending dropped", {31'b0, redirect}, 32'h0);

    // No boundary, no entry
    curReq = "R10";
    irqReq = 6'b010000; nmiReq = 1;
    repeat (4) begin
      tick();
      chk("R10", "no boundary", {31'b0, redirect}, 32'h0);
      nmiReq = 0;
    end
    idle();
    atBoundary = 1; tick(); idle();
    chk("R10", "boundary takes nmi", redirectPc, 32'h10);
    clrNp = 1; tick(); idle();

    // Mixed random traffic against the reference
    curReq = "R2";
    for (int n = 0; n < 4000; n++) begin
      atBoundary = ($urandom % 3) == 0;
      resetReq   = ($urandom % 60) == 0;
      nmiReq     = ($urandom % 12) == 0;
      clrNp      = ($urandom % 8) == 0;
      irqReq     = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      swIn       = $urandom & 32'hFF;
      pcIn       = $urandom;
      tick();
    end
    idle();
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule